// File: doc/BRIEF.md
# Clock-Synthesizer Register Port of a Video DAC

This block is the host-facing register file of a video DAC with an on-chip clock synthesizer. The host reaches it through four byte-wide ports chosen by a 2-bit port select. The select value is the port's offset from the base address, so 0 is the command port, 1 the read index, 2 the write index and 3 data. The command port holds the colour-mode byte, and it also answers a probe: four command reads in a row return a fixed identification code. The synthesizer registers are reached indirectly. The host loads an index, then moves bytes through the data port. Writes follow the write index and reads follow the read index, and each pointer has its own byte phase.

Index 2 is the programmable f2 clock entry, which holds two bytes: first the M byte, then the N byte. Index 0x0E is the one-byte synthesizer control register. The block exports the decoded divider values M, N1 and N2 and a colour-mode code. The divider outputs change only when a complete M/N pair has been written.

Top module: `dac_pll_regport`

## Requirements
- R1: During and after a synchronous active-high reset, the following values hold: bus_rdata is 0, the command byte and both indices are 0, colour_mode is 0, pll_m is 2, pll_n1 is 2 and pll_n2 is 0.
- R2: A command-port write stores the byte, and a later command read returns it unless R3 applies. colour_mode follows bits 7:5 of the written byte: 001 gives 1 (5-5-5), 011 gives 2 (5-6-5), 010 gives 3 (24-bit packed), and any other pattern gives 0 (8-bit indexed).
- R3: The fourth consecutive command-port read returns 0xB1 instead of the command byte. The count then starts again, so the eighth read in an unbroken run returns 0xB1 again.
- R4: Any write to any port, and any read of a port other than the command port, restarts the consecutive-read count. Idle cycles do not restart it.
- R5: The read index (select 1) and the write index (select 2) are separate registers that can be read back. Loading either one sets that pointer's byte phase to the first byte.
- R6: At index 2 (f2 entry), the first data byte goes to M and the second goes to N. The pointer then moves to the next index with the phase back on the first byte.
- R7: Writing the M byte leaves pll_m, pll_n1 and pll_n2 unchanged. These outputs update only in the cycle after the N byte of the f2 entry is written.
- R8: pll_m is the stored M byte plus 2. pll_n1 is bits 4:0 of the N byte plus 2. pll_n2 is bits 6:5 of the N byte.
- R9: Data reads at index 2 return the stored M byte and then the N byte, and then the read pointer advances. Reads never move the write pointer, and writes never move the read pointer.
- R10: Index 0x0E is a one-byte entry. Each data byte transferred there advances the pointer at once. Reads at 0x0E return the last control byte written.
- R11: At any index other than 2 and 0x0E, data writes store nothing and data reads return 0x00. The pointer still advances after every second byte.
- R12: A read returns its byte on bus_rdata in the cycle after the strobe. The value stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 2 | Port select: 0 command, 1 read index, 2 write index, 3 data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte (ignored when bus_wr is high) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pll_m | output | 9 | Decoded M divider |
| pll_n1 | output | 6 | Decoded N1 divider |
| pll_n2 | output | 2 | Decoded N2 post-divider exponent |
| colour_mode | output | 2 | Colour-mode code from the command byte |

## Verification
A wrong byte phase or a stray pointer step shows up one read later: a data read returns the wrong byte of the entry, or an index read-back is off by one. The divider outputs also take the wrong value on the cycle after the N write. A consecutive-read counter that is not cleared, or is cleared at the wrong time, moves the 0xB1 response to another read of a run. Each scenario therefore reads back the indices after its transfers, and probe runs are broken at chosen positions.

// File: rtl/dac_regport_pkg.sv
package dac_regport_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_WIDX = 2'd2,
    SEL_DATA = 2'd3
  } port_sel_e;

  typedef enum logic [1:0] {
    MODE_INDEXED = 2'd0,
    MODE_RGB555  = 2'd1,
    MODE_RGB565  = 2'd2,
    MODE_RGB888  = 2'd3
  } colour_mode_e;

  function automatic colour_mode_e decode_mode(input logic [2:0] hi);
    case (hi)
      3'b001:  decode_mode = MODE_RGB555;
      3'b011:  decode_mode = MODE_RGB565;
      3'b010:  decode_mode = MODE_RGB888;
      default: decode_mode = MODE_INDEXED;
    endcase
  endfunction

endpackage

// File: rtl/dac_id_detect.sv
module dac_id_detect #(
  parameter int ID_READS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_rd,
  input  logic clear,
  output logic hit
);
  localparam int CW = (ID_READS > 1) ? $clog2(ID_READS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ID_READS - 1);

  logic [CW-1:0] cnt_q;

  assign hit = cmd_rd && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (cmd_rd) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  // R4: a clearing access always restarts the run
  p_clear_count_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0));

  // R3: a hit ends the run, so the next read starts from zero
  p_hit_restart_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == '0));

endmodule

// File: rtl/dac_index_ptr.sv
module dac_index_ptr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  input  logic          one_byte,
  output logic [DW-1:0] idx,
  output logic          phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= 1'b0;
    end else if (load) begin
      idx   <= load_val;
      phase <= 1'b0;
    end else if (step) begin
      if (one_byte || phase) begin
        idx   <= idx + 1'b1;
        phase <= 1'b0;
      end else begin
        phase <= 1'b1;
      end
    end
  end

  // R5: loading an index restarts at the first byte
  p_load_phase_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == 1'b0) && (idx == $past(load_val)));

  // R6: the second byte of a pair always moves the pointer on
  p_pair_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && phase) |=> (idx == $past(idx) + 1'b1) && !phase);

  // R6: the first byte of a two-byte entry keeps the index
  p_first_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !phase && !one_byte) |=> $stable(idx));

endmodule

// File: rtl/dac_pll_regs.sv
module dac_pll_regs #(
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   F2_IDX   = 8'h02,
  parameter logic [DW-1:0]   CTRL_IDX = 8'h0E,
  parameter int              M_OFS    = 2,
  parameter int              N1_OFS   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_idx,
  input  logic          wr_phase,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_idx,
  input  logic          rd_phase,
  output logic [DW-1:0] rd_byte,
  output logic [DW:0]   m_out,
  output logic [5:0]    n1_out,
  output logic [1:0]    n2_out
);
  localparam logic [DW:0] M_ADD  = (DW+1)'(M_OFS);
  localparam logic [5:0]  N1_ADD = 6'(N1_OFS);

  logic [DW-1:0] f2_m_q, f2_n_q, ctrl_q;
  logic          f2_m_wr, f2_n_wr, ctrl_wr;

  assign f2_m_wr = wr_en && (wr_idx == F2_IDX) && !wr_phase;
  assign f2_n_wr = wr_en && (wr_idx == F2_IDX) && wr_phase;
  assign ctrl_wr = wr_en && (wr_idx == CTRL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      f2_m_q <= '0;
      f2_n_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (f2_m_wr) f2_m_q <= wdata;
      if (f2_n_wr) f2_n_q <= wdata;
      if (ctrl_wr) ctrl_q <= wdata;
    end
  end

  // exported dividers: loaded only when the pair is complete
  always_ff @(posedge clk) begin
    if (rst) begin
      m_out  <= M_ADD;
      n1_out <= N1_ADD;
      n2_out <= 2'd0;
    end else if (f2_n_wr) begin
      m_out  <= {1'b0, f2_m_q} + M_ADD;
      n1_out <= {1'b0, wdata[4:0]} + N1_ADD;
      n2_out <= wdata[6:5];
    end
  end

  always_comb begin
    if (rd_idx == F2_IDX)        rd_byte = rd_phase ? f2_n_q : f2_m_q;
    else if (rd_idx == CTRL_IDX) rd_byte = ctrl_q;
    else                         rd_byte = '0;
  end

  // R7: an M write alone never disturbs the exported dividers
  p_m_only_hold_r7: assert property (@(posedge clk) disable iff (rst)
    f2_m_wr |=> $stable(m_out) && $stable(n1_out) && $stable(n2_out));

  // R8: decoded dividers never fall below their offsets
  p_div_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (m_out >= M_ADD) && (n1_out >= N1_ADD));

  // R11: writes aimed at unmapped indices leave the stored bytes alone
  p_unmapped_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != F2_IDX && wr_idx != CTRL_IDX)
      |=> $stable(f2_m_q) && $stable(f2_n_q) && $stable(ctrl_q));

endmodule

// File: rtl/dac_pll_regport.sv
module dac_pll_regport
  import dac_regport_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] F2_IDX   = 8'h02,
  parameter logic [DW-1:0] CTRL_IDX = 8'h0E,
  parameter logic [DW-1:0] ID_CODE  = 8'hB1,
  parameter int            ID_READS = 4,
  parameter int            M_OFS    = 2,
  parameter int            N1_OFS   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW:0]   pll_m,
  output logic [5:0]    pll_n1,
  output logic [1:0]    pll_n2,
  output logic [1:0]    colour_mode
);
  logic          rd_any, rd_cmd, id_clear, id_hit;
  logic          wr_cmd, wr_ridx, wr_widx, wr_data, rd_data;
  logic [DW-1:0] cmd_q, rd_byte;
  logic [DW-1:0] ridx, widx;
  logic          rphase, wphase;
  colour_mode_e  mode_q;

  assign rd_any   = bus_rd && !bus_wr;
  assign rd_cmd   = rd_any && (bus_sel == SEL_CMD);
  assign rd_data  = rd_any && (bus_sel == SEL_DATA);
  assign wr_cmd   = bus_wr && (bus_sel == SEL_CMD);
  assign wr_ridx  = bus_wr && (bus_sel == SEL_RIDX);
  assign wr_widx  = bus_wr && (bus_sel == SEL_WIDX);
  assign wr_data  = bus_wr && (bus_sel == SEL_DATA);
  assign id_clear = bus_wr || (rd_any && (bus_sel != SEL_CMD));

  dac_id_detect #(.ID_READS(ID_READS)) u_id (
    .clk    (clk),
    .rst    (rst),
    .cmd_rd (rd_cmd),
    .clear  (id_clear),
    .hit    (id_hit)
  );

  dac_index_ptr #(.DW(DW)) u_rptr (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_ridx),
    .load_val (bus_wdata),
    .step     (rd_data),
    .one_byte (ridx == CTRL_IDX),
    .idx      (ridx),
    .phase    (rphase)
  );

  dac_index_ptr #(.DW(DW)) u_wptr (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_widx),
    .load_val (bus_wdata),
    .step     (wr_data),
    .one_byte (widx == CTRL_IDX),
    .idx      (widx),
    .phase    (wphase)
  );

  dac_pll_regs #(
    .DW(DW), .F2_IDX(F2_IDX), .CTRL_IDX(CTRL_IDX),
    .M_OFS(M_OFS), .N1_OFS(N1_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_data),
    .wr_idx   (widx),
    .wr_phase (wphase),
    .wdata    (bus_wdata),
    .rd_idx   (ridx),
    .rd_phase (rphase),
    .rd_byte  (rd_byte),
    .m_out    (pll_m),
    .n1_out   (pll_n1),
    .n2_out   (pll_n2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      mode_q <= MODE_INDEXED;
    end else if (wr_cmd) begin
      cmd_q  <= bus_wdata;
      mode_q <= decode_mode(bus_wdata[7:5]);
    end
  end

  assign colour_mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (bus_sel)
        SEL_CMD:  bus_rdata <= id_hit ? ID_CODE : cmd_q;
        SEL_RIDX: bus_rdata <= ridx;
        SEL_WIDX: bus_rdata <= widx;
        default:  bus_rdata <= rd_byte;
      endcase
    end
  end

  // R3: the probe hit shows the identification code on the next cycle
  p_id_code_r3: assert property (@(posedge clk) disable iff (rst)
    id_hit |=> (bus_rdata == ID_CODE));

  // R12: read data holds while no read is strobed
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(bus_rdata));

  // R9: reading never moves the write pointer
  p_rd_keeps_wptr_r9: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> $stable(widx) && $stable(wphase));

  // R2: colour mode only changes on a command write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_cmd |=> $stable(colour_mode));

endmodule

// File: tb/test_dac_pll_regport.sv
module test_dac_pll_regport;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [8:0] pll_m;
  logic [5:0] pll_n1;
  logic [1:0] pll_n2;
  logic [1:0] colour_mode;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pll_regport i_dac_pll_regport (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_m(pll_m),
    .pll_n1(pll_n1), .pll_n2(pll_n2), .colour_mode(colour_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 pll_m", pll_m, 2);
    chk("R1 pll_n1", pll_n1, 2);
    chk("R1 pll_n2", pll_n2, 0);
    chk("R1 mode", colour_mode, 0);
    rd(2'd2, v); chk("R1 write index", v, 0);
    rd(2'd1, v); chk("R1 read index", v, 0);
    rd(2'd0, v); chk("R1 command", v, 0);
  endtask

  task automatic t_cmd();
    logic [7:0] v;
    wr(2'd0, 8'h20); chk("R2 mode 555", colour_mode, 1);
    rd(2'd0, v);     chk("R2 readback", v, 8'h20);
    wr(2'd0, 8'h60); chk("R2 mode 565", colour_mode, 2);
    wr(2'd0, 8'h40); chk("R2 mode 888", colour_mode, 3);
    wr(2'd0, 8'hA0); chk("R2 mode other", colour_mode, 0);
    wr(2'd0, 8'h00); chk("R2 mode indexed", colour_mode, 0);
  endtask

  task automatic t_id();
    logic [7:0] v;
    wr(2'd0, 8'h60);
    for (int i = 1; i <= 8; i++) begin
      rd(2'd0, v);
      chk($sformatf("R3 probe read %0d", i), v, (i % 4 == 0) ? 8'hB1 : 8'h60);
    end
    // idle cycles keep the run going
    for (int i = 1; i <= 3; i++) rd(2'd0, v);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R4 idle keeps run", v, 8'hB1);
  endtask

  task automatic t_id_break();
    logic [7:0] v;
    for (int i = 0; i < 3; i++) rd(2'd0, v);
    rd(2'd2, v);
    rd(2'd0, v); chk("R4 other read restarts", v, 8'h60);
    rd(2'd0, v); rd(2'd0, v);
    wr(2'd1, 8'h00);
    rd(2'd0, v); chk("R4 write restarts", v, 8'h60);
    rd(2'd0, v); rd(2'd0, v);
    rd(2'd0, v); chk("R4 run after restart", v, 8'hB1);
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(2'd2, 8'h05); wr(2'd1, 8'h0E);
    rd(2'd2, v); chk("R5 write index", v, 8'h05);
    rd(2'd1, v); chk("R5 read index", v, 8'h0E);
  endtask

  task automatic t_f2_write();
    logic [7:0] v;
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h3F);
    chk("R7 m held", pll_m, 2);
    chk("R7 n1 held", pll_n1, 2);
    rd(2'd2, v); chk("R6 no advance after M", v, 8'h02);
    wr(2'd3, 8'h45);
    chk("R8 m", pll_m, 65);
    chk("R8 n1", pll_n1, 7);
    chk("R8 n2", pll_n2, 2);
    rd(2'd2, v); chk("R6 advance after N", v, 8'h03);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'hFF); wr(2'd3, 8'hFF);
    chk("R8 m max", pll_m, 257);
    chk("R8 n1 max", pll_n1, 33);
    chk("R8 n2 max", pll_n2, 3);
    // restore a known pair
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h3F); wr(2'd3, 8'h45);
  endtask

  task automatic t_phase_reload();
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h10);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h20); wr(2'd3, 8'h03);
    chk("R5 reload m", pll_m, 34);
    chk("R5 reload n1", pll_n1, 5);
    // put back the pair used by the read test
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h3F); wr(2'd3, 8'h45);
  endtask

  task automatic t_f2_read();
    logic [7:0] v;
    wr(2'd2, 8'h09);
    wr(2'd1, 8'h02);
    rd(2'd3, v); chk("R9 M byte", v, 8'h3F);
    rd(2'd1, v); chk("R9 no advance after M", v, 8'h02);
    rd(2'd3, v); chk("R9 N byte", v, 8'h45);
    rd(2'd1, v); chk("R9 read advance", v, 8'h03);
    rd(2'd2, v); chk("R9 write ptr untouched", v, 8'h09);
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", bus_rdata, 8'h09);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(2'd2, 8'h0E);
    wr(2'd3, 8'h5A);
    rd(2'd2, v); chk("R10 write single advance", v, 8'h0F);
    wr(2'd1, 8'h0E);
    rd(2'd3, v); chk("R10 ctrl read", v, 8'h5A);
    rd(2'd1, v); chk("R10 read single advance", v, 8'h0F);
  endtask

  task automatic t_other();
    logic [7:0] v;
    wr(2'd2, 8'h07);
    wr(2'd3, 8'h11);
    rd(2'd2, v); chk("R11 first byte holds idx", v, 8'h07);
    wr(2'd3, 8'h22);
    rd(2'd2, v); chk("R11 advance after pair", v, 8'h08);
    chk("R11 m unchanged", pll_m, 65);
    wr(2'd1, 8'h07);
    rd(2'd3, v); chk("R11 read zero", v, 0);
    wr(2'd1, 8'h02);
    rd(2'd3, v); chk("R11 f2 M intact", v, 8'h3F);
    rd(2'd3, v); chk("R11 f2 N intact", v, 8'h45);
    wr(2'd1, 8'h0E);
    rd(2'd3, v); chk("R11 ctrl intact", v, 8'h5A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cmd();
    t_id();
    t_id_break();
    t_index();
    t_f2_write();
    t_phase_reload();
    t_f2_read();
    t_ctrl();
    t_other();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule